// File: doc/BRIEF.md
# Write-Update Write-Back Snooping Cache Controller

This block is the coherence controller of one processor's cache on a shared snooping bus. It keeps a small direct-mapped array of single-word lines. Each line is in one of five conditions: empty, or one of four protocol states. Sole-clean means the only copy, matching memory. Shared-clean means one of several copies, with no ownership. Shared-owner means one of several copies, and this cache made the last write and owns the block. Modified means the only copy, changed and owned. A write to shared data does not invalidate the other copies. The new word is broadcast on the bus, and every other holder copies it in place. Memory is brought up to date only when an owned line is evicted.

The processor side has a request stream and a response stream, each with valid/ready. A request is taken on a cycle where both valid and ready are high. Ready is high only while the controller is idle. The response holds its valid and data unchanged until ready is seen high, so the processor may apply back-pressure for any number of cycles.

On the bus side the controller raises a request and keeps it until the grant arrives. Arbitration belongs to the environment. A granted transaction finishes in that one cycle. In the same cycle the controller samples the wired-OR shared line and the returned data word. As a snooper, it answers another master's transaction in the cycle it appears. It drives the shared line, and it also supplies its data when the transaction is a read.

Top module: `wuwb_snoop_ctrl`

## Requirements
- R1: After reset every line is empty, request ready is high, and no response, bus request, shared indication or data supply is active.
- R2: A read that hits returns the cached word and makes no bus request, and the line state is left unchanged.
- R3: A read miss issues a bus read (command 1) for the requested address. If the shared line is low at the grant, the line becomes sole-clean; if it is high, the line becomes shared-clean. The returned bus word is the response.
- R4: A snooped read (command 1) that hits asserts the shared line and supplies the line's word in the same cycle. A sole-clean or shared-clean line becomes shared-clean, and a modified or shared-owner line becomes shared-owner.
- R5: A write hit on a sole-clean or modified line updates the word locally, makes no bus request, and leaves the line modified.
- R6: A write hit on a shared-clean or shared-owner line issues an update broadcast (command 2) that carries the merged word. The line becomes shared-owner if the shared line is high at the grant, and modified if it is low.
- R7: A snooped update (command 2) that hits asserts the shared line, copies the broadcast word into the line and leaves it shared-clean.
- R8: A write miss first fetches with a bus read. If the shared line was low, the write is merged and the line becomes modified with no broadcast. If it was high, the merged word is broadcast with an update, and the line ends as R6 gives.
- R9: A miss that replaces a modified or shared-owner line first issues a write-back (command 3) carrying the old line address (victim tag above the index) and its word, then the fill. Replacing a clean line issues no write-back.
- R10: While a bus request waits for grant, its command and address do not change.
- R11: A response stays valid with unchanged data until accepted. A request is accepted only when ready is high.
- R12: Write data is merged by byte enables: bit i of the enable selects byte i (bits 8i+7..8i) of the write word, and the other bytes keep their old value.
- R13: A snooped transaction that misses, and any snooped write-back, produces no shared indication, no data supply and no change to any line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Controller can take a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write word |
| cpu_req_be | input | DATA_W/8 | Byte enables for writes |
| cpu_rsp_valid | output | 1 | Response valid |
| cpu_rsp_ready | input | 1 | Processor accepts response |
| cpu_rsp_rdata | output | DATA_W | Read word, or merged word for writes |
| bus_req | output | 1 | Bus transaction requested |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_cmd | output | 2 | 1 read, 2 update, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Update or write-back word |
| bus_rdata | input | DATA_W | Fill word from memory or a supplying cache |
| bus_shared_in | input | 1 | Wired-OR shared line, sampled at grant |
| snp_valid | input | 1 | Another master's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same codes as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_data | input | DATA_W | Snooped update word |
| snp_shared_out | output | 1 | This cache holds the snooped block |
| snp_supply_valid | output | 1 | This cache supplies the snooped read |
| snp_supply_data | output | DATA_W | Supplied word |

## Verification
The bench builds the controller with four lines, a six-bit address and a 32-bit word, and keeps its addresses within sixteen words. Four addresses therefore share each line. With that much aliasing, evictions of both owned and clean lines come often, and so do write misses that must first write back a shared-owner victim. Random shared-line values at each grant, random grant and response delays, and snoops of all three commands on held and absent blocks drive every line through all its transitions.

// File: rtl/wuwb_pkg.sv
package wuwb_pkg;

  typedef enum logic [2:0] {
    LS_INV   = 3'd0,
    LS_EXCL  = 3'd1,
    LS_SHCLN = 3'd2,
    LS_SHDRT = 3'd3,
    LS_MOD   = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE   = 2'd0,
    BC_READ   = 2'd1,
    BC_UPDATE = 2'd2,
    BC_WBACK  = 2'd3
  } bus_cmd_e;

  typedef enum logic [2:0] {
    RQ_IDLE,
    RQ_LOOKUP,
    RQ_WBACK,
    RQ_FILL,
    RQ_UPDATE,
    RQ_RESP
  } rq_st_e;

  function automatic logic is_owner(line_st_e s);
    return (s == LS_SHDRT) || (s == LS_MOD);
  endfunction

endpackage

// File: rtl/wuwb_byte_merge.sv
module wuwb_byte_merge #(
  parameter int DATA_W = 32,
  localparam int BE_W = DATA_W / 8
) (
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BE_W-1:0]   be,
  output logic [DATA_W-1:0] merged
);

  for (genvar g = 0; g < BE_W; g++) begin : g_byte
    assign merged[g*8 +: 8] = be[g] ? wdata[g*8 +: 8] : base[g*8 +: 8];
  end

endmodule

// File: rtl/wuwb_line_store.sv
module wuwb_line_store
  import wuwb_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int TAG_W  = 7,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  // requester read port
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_e          a_state,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  // snooper read port
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_e          b_state,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  // requester write port
  input  logic              wa_en,
  input  logic [IDX_W-1:0]  wa_idx,
  input  line_st_e          wa_state,
  input  logic [TAG_W-1:0]  wa_tag,
  input  logic [DATA_W-1:0] wa_data,
  // snooper write port (tag is kept)
  input  logic              wb_en,
  input  logic [IDX_W-1:0]  wb_idx,
  input  line_st_e          wb_state,
  input  logic [DATA_W-1:0] wb_data
);

  line_st_e          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]   <= LS_INV;
        tag_q[g]  <= '0;
        data_q[g] <= '0;
      end else if (wa_en && (wa_idx == MY_IDX)) begin
        st_q[g]   <= wa_state;
        tag_q[g]  <= wa_tag;
        data_q[g] <= wa_data;
      end else if (wb_en && (wb_idx == MY_IDX)) begin
        st_q[g]   <= wb_state;
        data_q[g] <= wb_data;
      end
    end
  end

  assign a_state = st_q[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign a_data  = data_q[a_idx];
  assign b_state = st_q[b_idx];
  assign b_tag   = tag_q[b_idx];
  assign b_data  = data_q[b_idx];

  // R4
  snoop_keeps_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_state != LS_INV));

  // R13
  port_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wa_en && wb_en && (wa_idx == wb_idx)));

endmodule

// File: rtl/wuwb_snoop_unit.sv
module wuwb_snoop_unit
  import wuwb_pkg::*;
#(
  parameter int TAG_W  = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  logic [DATA_W-1:0] snp_data,
  input  line_st_e          ln_state,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic [DATA_W-1:0] ln_data,
  output logic              shared_out,
  output logic              supply_valid,
  output logic [DATA_W-1:0] supply_data,
  output logic              upd_en,
  output line_st_e          upd_state,
  output logic [DATA_W-1:0] upd_data
);

  logic hold;
  assign hold        = snp_valid && (ln_state != LS_INV) && (ln_tag == snp_tag);
  assign supply_data = ln_data;

  always_comb begin
    shared_out   = 1'b0;
    supply_valid = 1'b0;
    upd_en       = 1'b0;
    upd_state    = ln_state;
    upd_data     = ln_data;
    case (bus_cmd_e'(snp_cmd))
      BC_READ: begin
        shared_out   = hold;
        supply_valid = hold;
        upd_en       = hold;
        upd_state    = is_owner(ln_state) ? LS_SHDRT : LS_SHCLN;
      end
      BC_UPDATE: begin
        shared_out = hold;
        upd_en     = hold;
        upd_state  = LS_SHCLN;
        upd_data   = snp_data;
      end
      default: ;
    endcase
  end

  // R4
  supply_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply_valid |-> shared_out);

  // R13
  quiet_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snp_valid || (ln_state == LS_INV)) |-> (!shared_out && !upd_en));

endmodule

// File: rtl/wuwb_requester.sv
module wuwb_requester
  import wuwb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  input  logic [BE_W-1:0]   cpu_req_be,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [IDX_W-1:0]  snp_idx,
  output logic [IDX_W-1:0]  ln_idx,
  input  line_st_e          ln_state,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic [DATA_W-1:0] ln_data,
  output logic              wr_en,
  output line_st_e          wr_state,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_data
);

  rq_st_e            st_q, st_d;
  logic              r_write;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;
  logic [BE_W-1:0]   r_be;
  logic [DATA_W-1:0] rsp_q, rsp_d;

  logic [TAG_W-1:0]  r_tag;
  logic              ln_hit, stall;
  logic [DATA_W-1:0] mrg_base, mrg_data;

  assign ln_idx   = r_addr[IDX_W-1:0];
  assign r_tag    = r_addr[ADDR_W-1:IDX_W];
  assign ln_hit   = (ln_state != LS_INV) && (ln_tag == r_tag);
  assign stall    = snp_valid && (snp_idx == ln_idx);
  assign mrg_base = (st_q == RQ_FILL) ? bus_rdata : ln_data;

  wuwb_byte_merge #(.DATA_W(DATA_W)) merge_i (
    .base   (mrg_base),
    .wdata  (r_wdata),
    .be     (r_be),
    .merged (mrg_data)
  );

  assign cpu_req_ready = (st_q == RQ_IDLE);
  assign cpu_rsp_valid = (st_q == RQ_RESP);
  assign cpu_rsp_rdata = rsp_q;
  assign bus_req       = (st_q == RQ_WBACK) || (st_q == RQ_FILL) || (st_q == RQ_UPDATE);

  always_comb begin
    bus_cmd   = BC_NONE;
    bus_addr  = r_addr;
    bus_wdata = '0;
    case (st_q)
      RQ_WBACK: begin
        bus_cmd   = BC_WBACK;
        bus_addr  = {ln_tag, ln_idx};
        bus_wdata = ln_data;
      end
      RQ_FILL:   bus_cmd = BC_READ;
      RQ_UPDATE: begin
        bus_cmd   = BC_UPDATE;
        bus_wdata = mrg_data;
      end
      default: ;
    endcase
  end

  always_comb begin
    st_d     = st_q;
    rsp_d    = rsp_q;
    wr_en    = 1'b0;
    wr_state = ln_state;
    wr_tag   = ln_tag;
    wr_data  = ln_data;
    case (st_q)
      RQ_IDLE: if (cpu_req_valid) st_d = RQ_LOOKUP;
      RQ_LOOKUP: begin
        if (!stall) begin
          if (ln_hit) begin
            if (!r_write) begin
              rsp_d = ln_data;
              st_d  = RQ_RESP;
            end else if ((ln_state == LS_EXCL) || (ln_state == LS_MOD)) begin
              wr_en    = 1'b1;
              wr_state = LS_MOD;
              wr_data  = mrg_data;
              rsp_d    = mrg_data;
              st_d     = RQ_RESP;
            end else begin
              st_d = RQ_UPDATE;
            end
          end else if (is_owner(ln_state)) begin
            st_d = RQ_WBACK;
          end else begin
            st_d = RQ_FILL;
          end
        end
      end
      RQ_WBACK: begin
        if (bus_gnt) begin
          wr_en    = 1'b1;
          wr_state = LS_INV;
          st_d     = RQ_FILL;
        end
      end
      RQ_FILL: begin
        if (bus_gnt) begin
          wr_en  = 1'b1;
          wr_tag = r_tag;
          if (!r_write) begin
            wr_data  = bus_rdata;
            wr_state = bus_shared_in ? LS_SHCLN : LS_EXCL;
            rsp_d    = bus_rdata;
            st_d     = RQ_RESP;
          end else if (bus_shared_in) begin
            wr_data  = bus_rdata;
            wr_state = LS_SHCLN;
            st_d     = RQ_UPDATE;
          end else begin
            wr_data  = mrg_data;
            wr_state = LS_MOD;
            rsp_d    = mrg_data;
            st_d     = RQ_RESP;
          end
        end
      end
      RQ_UPDATE: begin
        if (bus_gnt) begin
          wr_en    = 1'b1;
          wr_data  = mrg_data;
          wr_state = bus_shared_in ? LS_SHDRT : LS_MOD;
          rsp_d    = mrg_data;
          st_d     = RQ_RESP;
        end
      end
      RQ_RESP: if (cpu_rsp_ready) st_d = RQ_IDLE;
      default: st_d = RQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= RQ_IDLE;
      rsp_q   <= '0;
      r_write <= 1'b0;
      r_addr  <= '0;
      r_wdata <= '0;
      r_be    <= '0;
    end else begin
      st_q  <= st_d;
      rsp_q <= rsp_d;
      if (cpu_req_valid && cpu_req_ready) begin
        r_write <= cpu_req_write;
        r_addr  <= cpu_req_addr;
        r_wdata <= cpu_req_wdata;
        r_be    <= cpu_req_be;
      end
    end
  end

  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && !cpu_rsp_ready) |=> (cpu_rsp_valid && $stable(cpu_rsp_rdata)));

  // R9
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && (bus_cmd == BC_WBACK)) |=> (bus_req && (bus_cmd == BC_READ)));

  // R2
  hit_read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && !bus_req) |-> !wr_en);

endmodule

// File: rtl/wuwb_snoop_ctrl.sv
module wuwb_snoop_ctrl
  import wuwb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  input  logic [BE_W-1:0]   cpu_req_be,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_data,
  output logic              snp_shared_out,
  output logic              snp_supply_valid,
  output logic [DATA_W-1:0] snp_supply_data
);

  logic [IDX_W-1:0]  snp_idx, rq_idx;
  logic [TAG_W-1:0]  snp_tag;
  line_st_e          rq_state, sn_state, rq_wstate, sn_wstate;
  logic [TAG_W-1:0]  rq_tag, sn_tag, rq_wtag;
  logic [DATA_W-1:0] rq_data, sn_data, rq_wdata, sn_wdata;
  logic              rq_wen, sn_wen;

  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

  wuwb_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_idx    (rq_idx),
    .a_state  (rq_state),
    .a_tag    (rq_tag),
    .a_data   (rq_data),
    .b_idx    (snp_idx),
    .b_state  (sn_state),
    .b_tag    (sn_tag),
    .b_data   (sn_data),
    .wa_en    (rq_wen),
    .wa_idx   (rq_idx),
    .wa_state (rq_wstate),
    .wa_tag   (rq_wtag),
    .wa_data  (rq_wdata),
    .wb_en    (sn_wen),
    .wb_idx   (snp_idx),
    .wb_state (sn_wstate),
    .wb_data  (sn_wdata)
  );

  wuwb_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) snoop_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .snp_valid    (snp_valid),
    .snp_cmd      (snp_cmd),
    .snp_tag      (snp_tag),
    .snp_data     (snp_data),
    .ln_state     (sn_state),
    .ln_tag       (sn_tag),
    .ln_data      (sn_data),
    .shared_out   (snp_shared_out),
    .supply_valid (snp_supply_valid),
    .supply_data  (snp_supply_data),
    .upd_en       (sn_wen),
    .upd_state    (sn_wstate),
    .upd_data     (sn_wdata)
  );

  wuwb_requester #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) req_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_ready (cpu_req_ready),
    .cpu_req_write (cpu_req_write),
    .cpu_req_addr  (cpu_req_addr),
    .cpu_req_wdata (cpu_req_wdata),
    .cpu_req_be    (cpu_req_be),
    .cpu_rsp_valid (cpu_rsp_valid),
    .cpu_rsp_ready (cpu_rsp_ready),
    .cpu_rsp_rdata (cpu_rsp_rdata),
    .bus_req       (bus_req),
    .bus_gnt       (bus_gnt),
    .bus_cmd       (bus_cmd),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .bus_shared_in (bus_shared_in),
    .snp_valid     (snp_valid),
    .snp_idx       (snp_idx),
    .ln_idx        (rq_idx),
    .ln_state      (rq_state),
    .ln_tag        (rq_tag),
    .ln_data       (rq_data),
    .wr_en         (rq_wen),
    .wr_state      (rq_wstate),
    .wr_tag        (rq_wtag),
    .wr_data       (rq_wdata)
  );

  // R10
  gnt_snoop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_gnt |-> !snp_valid);

endmodule

// File: tb/wuwb_snoop_ctrl_tb.sv
module wuwb_snoop_ctrl_tb_top;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int LINES  = 4;
  localparam int S_INV = 0, S_EXCL = 1, S_SHC = 2, S_SHD = 3, S_MOD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req_valid = 0, cpu_req_write = 0, cpu_rsp_ready = 0;
  logic [ADDR_W-1:0] cpu_req_addr = '0;
  logic [DATA_W-1:0] cpu_req_wdata = '0;
  logic [3:0] cpu_req_be = '0;
  logic cpu_req_ready, cpu_rsp_valid;
  logic [DATA_W-1:0] cpu_rsp_rdata;
  logic bus_req, bus_gnt = 0, bus_shared_in = 0;
  logic [1:0] bus_cmd;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata = '0;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = '0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic [DATA_W-1:0] snp_data = '0;
  logic snp_shared_out, snp_supply_valid;
  logic [DATA_W-1:0] snp_supply_data;

  int unsigned n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  int          m_st   [LINES];
  logic [3:0]  m_tag  [LINES];
  logic [31:0] m_data [LINES];

  always #10 clk = ~clk;

  wuwb_snoop_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_req_be(cpu_req_be),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready),
    .cpu_rsp_rdata(cpu_rsp_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_shared_in(bus_shared_in),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_data(snp_data),
    .snp_shared_out(snp_shared_out), .snp_supply_valid(snp_supply_valid),
    .snp_supply_data(snp_supply_data)
  );

  task automatic check(bit ok, string tg, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tg, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = be[i] ? nw[i*8 +: 8] : old[i*8 +: 8];
    return r;
  endfunction

  function automatic bit owned(int s);
    return (s == S_SHD) || (s == S_MOD);
  endfunction

  task automatic cpu_op(bit wr, logic [5:0] a, logic [31:0] wd, logic [3:0] be, bit sh0, bit sh1);
    int idx;
    logic [3:0] t;
    bit hit;
    int n, k, d, guard;
    bit done, acc, first;
    logic [1:0]  ecmd [3];
    logic [5:0]  eadr [3];
    logic [31:0] edat [3];
    bit          echk [3];
    bit          esh  [3];
    logic [31:0] erd  [3];
    string       btg  [3];
    string       tg;
    logic [31:0] fill, exp_rsp, mg;
    idx = int'(a[1:0]);
    t = a[5:2];
    hit = (m_st[idx] != S_INV) && (m_tag[idx] == t);
    fill = $urandom;
    n = 0;
    first = 1;
    for (int i = 0; i < 3; i++) begin
      ecmd[i] = 0; eadr[i] = 0; edat[i] = 0; echk[i] = 0; esh[i] = 0; erd[i] = 0; btg[i] = "R3";
    end
    if (hit && !wr) begin
      tg = "R2"; exp_rsp = m_data[idx];
    end else if (hit && (m_st[idx] == S_EXCL || m_st[idx] == S_MOD)) begin
      tg = (be == 4'hF) ? "R5" : "R12";
      exp_rsp = merge(m_data[idx], wd, be);
      m_data[idx] = exp_rsp; m_st[idx] = S_MOD;
    end else if (hit) begin
      tg = "R6";
      mg = merge(m_data[idx], wd, be);
      ecmd[0] = 2; eadr[0] = a; edat[0] = mg; echk[0] = 1; esh[0] = sh0; btg[0] = "R6"; n = 1;
      exp_rsp = mg; m_data[idx] = mg; m_st[idx] = sh0 ? S_SHD : S_MOD;
    end else begin
      if (owned(m_st[idx])) begin
        ecmd[n] = 3; eadr[n] = {m_tag[idx], a[1:0]}; edat[n] = m_data[idx]; echk[n] = 1;
        btg[n] = "R9"; n++;
      end
      ecmd[n] = 1; eadr[n] = a; esh[n] = sh0; erd[n] = fill; btg[n] = wr ? "R8" : "R3"; n++;
      m_tag[idx] = t;
      if (!wr) begin
        tg = "R3"; exp_rsp = fill; m_data[idx] = fill; m_st[idx] = sh0 ? S_SHC : S_EXCL;
      end else begin
        tg = "R8";
        mg = merge(fill, wd, be);
        exp_rsp = mg; m_data[idx] = mg;
        if (sh0) begin
          ecmd[n] = 2; eadr[n] = a; edat[n] = mg; echk[n] = 1; esh[n] = sh1; btg[n] = "R8"; n++;
          m_st[idx] = sh1 ? S_SHD : S_MOD;
        end else begin
          m_st[idx] = S_MOD;
        end
      end
    end
    // request handshake (R11)
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = wd; cpu_req_be = be;
    guard = 0;
    while (1) begin
      #1 acc = cpu_req_ready;
      @(posedge clk);
      #1;
      if (acc || guard > 50) break;
      guard++;
      @(negedge clk);
    end
    cpu_req_valid = 0;
    k = 0; done = 0; guard = 0;
    while (!done && guard < 80) begin
      guard++;
      @(negedge clk);
      #1;
      if (bus_req) begin
        if (k >= n) begin
          check(0, tg, "unexpected bus request cmd", 64'(bus_cmd), 0);
        end else begin
          check(bus_cmd == ecmd[k], btg[k], "bus cmd", 64'(bus_cmd), 64'(ecmd[k]));
          check(bus_addr == eadr[k], btg[k], "bus addr", 64'(bus_addr), 64'(eadr[k]));
          if (echk[k]) check(bus_wdata == edat[k], btg[k], "bus data", 64'(bus_wdata), 64'(edat[k]));
          d = $urandom % 3;
          repeat (d) begin
            @(negedge clk);
            #1;
            check(bus_req && bus_cmd == ecmd[k] && bus_addr == eadr[k], "R10", "held request",
                  {bus_req, bus_cmd, bus_addr}, {1'b1, ecmd[k], eadr[k]});
          end
        end
        bus_gnt = 1;
        bus_shared_in = (k < n) ? esh[k] : 1'b0;
        bus_rdata = (k < n) ? erd[k] : 32'h0;
        @(posedge clk);
        #1;
        bus_gnt = 0; bus_shared_in = 0;
        k++;
      end else if (cpu_rsp_valid) begin
        check(k == n, tg, "bus transaction count", 64'(k), 64'(n));
        check(cpu_rsp_rdata == exp_rsp, tg, "response data", 64'(cpu_rsp_rdata), 64'(exp_rsp));
        d = $urandom % 3;
        repeat (d) begin
          @(negedge clk);
          #1;
          check(cpu_rsp_valid && cpu_rsp_rdata == exp_rsp, "R11", "held response",
                64'(cpu_rsp_rdata), 64'(exp_rsp));
        end
        cpu_rsp_ready = 1;
        @(posedge clk);
        #1;
        cpu_rsp_ready = 0;
        done = 1;
      end
    end
    if (!done) check(0, tg, "no response", 0, 1);
    first = 0;
  endtask

  task automatic snoop_op(logic [1:0] cmd, logic [5:0] a, logic [31:0] d);
    int idx;
    bit hit;
    idx = int'(a[1:0]);
    hit = (m_st[idx] != S_INV) && (m_tag[idx] == a[5:2]);
    @(negedge clk);
    snp_valid = 1; snp_cmd = cmd; snp_addr = a; snp_data = d;
    #1;
    if (!hit || cmd == 3) begin
      // R13: no reaction to a miss or a write-back
      check(!snp_shared_out && !snp_supply_valid, "R13", "quiet snoop",
            {snp_shared_out, snp_supply_valid}, 0);
    end else if (cmd == 1) begin
      check(snp_shared_out && snp_supply_valid, "R4", "shared and supply",
            {snp_shared_out, snp_supply_valid}, 2'b11);
      check(snp_supply_data == m_data[idx], "R4", "supplied word",
            64'(snp_supply_data), 64'(m_data[idx]));
      m_st[idx] = owned(m_st[idx]) ? S_SHD : S_SHC;
    end else begin
      check(snp_shared_out && !snp_supply_valid, "R7", "update shared",
            {snp_shared_out, snp_supply_valid}, 2'b10);
      m_data[idx] = d;
      m_st[idx] = S_SHC;
    end
    @(posedge clk);
    #1;
    snp_valid = 0;
  endtask

  initial begin
    void'($urandom(32'd91573));
    for (int i = 0; i < LINES; i++) begin
      m_st[i] = S_INV; m_tag[i] = 0; m_data[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    #1;
    // R1: reset state
    check(cpu_req_ready && !cpu_rsp_valid, "R1", "handshake after reset",
          {cpu_req_ready, cpu_rsp_valid}, 2'b10);
    check(!bus_req && !snp_shared_out && !snp_supply_valid, "R1", "bus quiet after reset",
          {bus_req, snp_shared_out, snp_supply_valid}, 0);
    // R1: all lines empty, so the first read misses (expected READ from model)
    cpu_op(0, 6'h05, 0, 0, 0, 0);                    // R3 sole-clean
    cpu_op(1, 6'h05, 32'hAABBCCDD, 4'b0011, 0, 0);   // R5/R12 local write
    snoop_op(1, 6'h05, 0);                           // R4 modified -> shared-owner
    cpu_op(0, 6'h05, 0, 0, 0, 0);                    // R2 read hit
    cpu_op(0, 6'h15, 0, 0, 1, 0);                    // R9 write-back, then R3 shared-clean
    cpu_op(1, 6'h15, 32'h12345678, 4'hF, 0, 0);      // R6 broadcast, shared low -> modified
    cpu_op(1, 6'h15, 32'h0000FF00, 4'b0010, 0, 0);   // R5 local now
    snoop_op(2, 6'h09, 32'h55);                      // R13 miss
    cpu_op(0, 6'h09, 0, 0, 1, 0);                    // R3 shared-clean
    snoop_op(2, 6'h09, 32'hCAFEF00D);                // R7 copy
    cpu_op(0, 6'h09, 0, 0, 0, 0);                    // R7 data visible via hit
    snoop_op(3, 6'h09, 32'h1);                       // R13 write-back ignored
    cpu_op(0, 6'h09, 0, 0, 0, 0);                    // R13 word unchanged
    cpu_op(1, 6'h0A, 32'h0BADBEEF, 4'hF, 1, 1);      // R8 shared write miss -> shared-owner
    cpu_op(0, 6'h1A, 0, 0, 0, 0);                    // R9 write-back of shared-owner
    cpu_op(1, 6'h0B, 32'h77777777, 4'b1001, 0, 0);   // R8 exclusive write miss
    cpu_op(1, 6'h0B, 32'h11111111, 4'hF, 0, 0);      // R5 confirms modified
    cpu_op(0, 6'h2B, 0, 0, 0, 0);                    // R9 write-back of modified
    cpu_op(0, 6'h0F, 0, 0, 0, 0);                    // sole-clean
    snoop_op(1, 6'h0F, 0);                           // R4 sole-clean -> shared-clean
    cpu_op(1, 6'h0F, 32'h3, 4'h1, 1, 0);             // R6 broadcast, shared high -> shared-owner
    for (int it = 0; it < 400; it++) begin
      int r;
      logic [5:0] a;
      logic [1:0] c;
      int ix;
      r = $urandom % 10;
      a = 6'($urandom % 16);
      if (r < 6) begin
        cpu_op(1'($urandom), a, $urandom, 4'($urandom), 1'($urandom), 1'($urandom));
      end else begin
        c = 2'(1 + $urandom % 3);
        ix = int'(a[1:0]);
        if (c == 2 && m_tag[ix] == a[5:2] && (m_st[ix] == S_EXCL || m_st[ix] == S_MOD)) c = 1;
        snoop_op(c, a, $urandom);
      end
    end
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule